// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block sits between a host address path and a DRAM array organised as eight rows. Software fills in one boundary value per row. Each boundary is the running total of memory from row 0 up to and including that row, counted in 8 MB steps. A row that has no devices simply repeats the total of the row before it, so the rows may be populated in any combination. The same write also records whether the row is built from 16 Mb or 64 Mb devices. That choice decides which host address bits become the bank-select lines.

For each lookup the host presents an address and a byte-enable pattern with a valid strobe. One clock later the block drives the active-low select of the matching row. The select comes out twice, as two identical copies for electrical loading. The block also drives the bank-select pair, the byte-lane strobes and a hit or miss flag. A single memory-type input chooses between synchronous mode and RAS/CAS mode. In synchronous mode the lane outputs act as data masks. In RAS/CAS mode the row selects act as row strobes and the lane outputs act as column strobes. Boundary writes that arrive while a lookup is in progress are parked and applied once the strobe drops.

Top module: `row_bound_dec`

## Requirements
- R1: After reset, all row selects are high, `hit` and `miss` are low, `lane_n` is 8'hFF, `bank_sel` is 0, and every boundary is zero, so any lookup misses.
- R2: The page of an address is `req_addr[31:23]` (8 MB units). Row i owns the pages from the boundary of row i-1 (0 for row 0) up to, but not including, the boundary of row i. When `req_valid` is high, the owning row's bit of `sel_a_n` goes low in the next cycle and all other bits stay high.
- R3: The row selected is the lowest-numbered row whose boundary is greater than the page. A row whose boundary equals its predecessor's boundary is never selected.
- R4: `sel_b_n` always equals `sel_a_n`.
- R5: A page at or above every boundary gives `miss`=1, `hit`=0, no row select and `bank_sel`=0 in the next cycle. `hit` and `miss` are never high together.
- R6: On a hit in a row marked 16 Mb (`cfg_dense`=0), `bank_sel` = {1'b0, `req_addr[12]`}.
- R7: On a hit in a row marked 64 Mb (`cfg_dense`=1), `bank_sel` = `req_addr[14:13]`.
- R8: With `mode_rascas`=0, `lane_n` = ~`req_be` one cycle after every valid lookup, whether it hits or misses. With `mode_rascas`=1, `lane_n` = ~`req_be` after a hit and 8'hFF after a miss.
- R9: One cycle after a cycle with `req_valid` low, all selects are high, `hit`=`miss`=0, `lane_n`=8'hFF and `bank_sel`=0.
- R10: A `cfg_wr` in a cycle with `req_valid` high does not affect lookups while the strobe stays high. It takes effect at the first clock edge where `req_valid` is low, so it governs the lookups that follow.
- R11: While a write is parked, a later write in the same stall replaces it. When a new write arrives in the cycle the parked one lands and both target the same row, the new write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Boundary/density write strobe |
| cfg_row | input | 3 | Row index being written |
| cfg_bound | input | 8 | Cumulative boundary in 8 MB units |
| cfg_dense | input | 1 | Device density: 0 = 16 Mb, 1 = 64 Mb |
| mode_rascas | input | 1 | Memory type: 0 = synchronous, 1 = RAS/CAS |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Host byte address |
| req_be | input | 8 | Byte enables, active high |
| sel_a_n | output | 8 | Row select copy A, active low |
| sel_b_n | output | 8 | Row select copy B, active low |
| lane_n | output | 8 | Byte masks (synchronous) or column strobes (RAS/CAS), active low |
| bank_sel | output | 2 | Bank-select lines |
| hit | output | 1 | Lookup found a row |
| miss | output | 1 | Lookup above all populated memory |

## Verification
The hardest case to reach is a boundary write that collides with a lookup. The write has to be issued while the strobe is held high across several cycles. A second write then has to overwrite the parked one. A third write has to arrive in the very cycle the parked value lands. The stimulus holds `req_valid` high on a fixed page while it issues these writes. It picks boundary values so that the parked write, the superseded write and the winning write each send a later lookup to a different row, or to a miss. The reference model applies writes in the order the requirements give, so any wrong ordering shows up as a wrong select.

// File: rtl/row_bound_pkg.sv
package row_bound_pkg;

  typedef enum logic {
    DENS_16M = 1'b0,
    DENS_64M = 1'b1
  } dens_e;

  typedef enum logic {
    MT_SYNC   = 1'b0,
    MT_RASCAS = 1'b1
  } memtype_e;

  // Bank lines for a hit: one address bit for small devices, two for large.
  function automatic logic [1:0] bank_pick(input logic [63:0] addr,
                                           input logic        dense,
                                           input int          pos16,
                                           input int          pos64);
    logic [63:0] s16;
    logic [63:0] s64;
    s16 = addr >> pos16;
    s64 = addr >> pos64;
    return dense ? {s64[1], s64[0]} : {1'b0, s16[0]};
  endfunction

  // Byte-lane drive: synchronous masks follow the enables on every lookup,
  // column strobes stay idle when no row answers.
  function automatic logic lane_idle(input logic rascas, input logic any_row);
    return rascas && !any_row;
  endfunction

endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        wr,
  input  logic [ROW_W-1:0]            wr_row,
  input  logic [BND_W-1:0]            wr_bound,
  input  logic                        wr_dense,
  output logic [ROWS-1:0][BND_W-1:0]  bounds,
  output logic [ROWS-1:0]             dense,
  output logic                        pend_valid,
  output logic                        commit_any
);

  logic [ROW_W-1:0] pend_row;
  logic [BND_W-1:0] pend_bound;
  logic             pend_dense;
  logic             commit_new;
  logic             commit_pend;

  assign commit_new  = wr && !busy;
  assign commit_pend = pend_valid && !busy;
  assign commit_any  = commit_new || commit_pend;

  // Parking slot for a write that met an active lookup; the newest one wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_row   <= '0;
      pend_bound <= '0;
      pend_dense <= 1'b0;
    end else if (busy && wr) begin
      pend_valid <= 1'b1;
      pend_row   <= wr_row;
      pend_bound <= wr_bound;
      pend_dense <= wr_dense;
    end else if (!busy) begin
      pend_valid <= 1'b0;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit_new;
    logic hit_pend;
    assign hit_new  = commit_new  && (wr_row   == ROW_W'(r));
    assign hit_pend = commit_pend && (pend_row == ROW_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bounds[r] <= '0;
        dense[r]  <= 1'b0;
      end else if (hit_new) begin
        bounds[r] <= wr_bound;
        dense[r]  <= wr_dense;
      end else if (hit_pend) begin
        bounds[r] <= pend_bound;
        dense[r]  <= pend_dense;
      end
    end
  end

endmodule

// File: rtl/rbd_match.sv
module rbd_match #(
  parameter int ROWS   = 8,
  parameter int BND_W  = 8,
  parameter int PAGE_W = 9,
  localparam int CMP_W = (BND_W > PAGE_W) ? BND_W : PAGE_W
) (
  input  logic [PAGE_W-1:0]           page,
  input  logic [ROWS-1:0][BND_W-1:0]  bounds,
  input  logic [ROWS-1:0]             dense,
  output logic [ROWS-1:0]             sel,
  output logic                        any_row,
  output logic                        dense_hit
);

  logic [ROWS-1:0] above;
  logic [ROWS:0]   seen;
  logic [CMP_W-1:0] page_x;

  assign page_x  = CMP_W'(page);
  assign seen[0] = 1'b0;

  // Lowest row whose running total lies beyond the page; empty rows lose to
  // the row below them because that row already sees the same total.
  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign above[r]  = page_x < CMP_W'(bounds[r]);
    assign sel[r]    = above[r] && !seen[r];
    assign seen[r+1] = seen[r] || above[r];
  end

  assign any_row   = seen[ROWS];
  assign dense_hit = |(sel & dense);

endmodule

// File: rtl/rbd_out.sv
module rbd_out #(
  parameter int ROWS   = 8,
  parameter int LANES  = 8,
  parameter int COPIES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             rascas,
  input  logic [ROWS-1:0]  sel,
  input  logic             any_row,
  input  logic [LANES-1:0] be,
  input  logic [1:0]       bank_in,
  output logic [COPIES-1:0][ROWS-1:0] sel_n,
  output logic [LANES-1:0] lane_n,
  output logic [1:0]       bank_sel,
  output logic             hit,
  output logic             miss
);
  import row_bound_pkg::*;

  // Separate flops per copy so each drives its own load.
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_n[c] <= '1;
      else if (valid) sel_n[c] <= ~sel;
      else            sel_n[c] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_n   <= '1;
      bank_sel <= '0;
      hit      <= 1'b0;
      miss     <= 1'b0;
    end else if (valid) begin
      lane_n   <= lane_idle(rascas, any_row) ? '1 : ~be;
      bank_sel <= any_row ? bank_in : 2'b00;
      hit      <= any_row;
      miss     <= !any_row;
    end else begin
      lane_n   <= '1;
      bank_sel <= '0;
      hit      <= 1'b0;
      miss     <= 1'b0;
    end
  end

endmodule

// File: rtl/row_bound_dec.sv
module row_bound_dec #(
  parameter int ROWS     = 8,
  parameter int ADDR_W   = 32,
  parameter int BND_W    = 8,
  parameter int UNIT_LSB = 23,
  parameter int LANES    = 8,
  parameter int BA16_BIT = 12,
  parameter int BA64_LSB = 13,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int PAGE_W  = ADDR_W - UNIT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [BND_W-1:0]  cfg_bound,
  input  logic              cfg_dense,
  input  logic              mode_rascas,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  output logic [ROWS-1:0]   sel_a_n,
  output logic [ROWS-1:0]   sel_b_n,
  output logic [LANES-1:0]  lane_n,
  output logic [1:0]        bank_sel,
  output logic              hit,
  output logic              miss
);
  import row_bound_pkg::*;

  logic [ROWS-1:0][BND_W-1:0] bounds;
  logic [ROWS-1:0]            dense;
  logic                       pend_valid;
  logic                       commit_any;
  logic [PAGE_W-1:0]          page;
  logic [ROWS-1:0]            sel_nxt;
  logic                       any_nxt;
  logic                       dense_hit;
  logic [1:0]                 bank_nxt;
  logic [1:0][ROWS-1:0]       sel_copies;

  assign page     = req_addr[ADDR_W-1:UNIT_LSB];
  assign bank_nxt = bank_pick(64'(req_addr), dense_hit, BA16_BIT, BA64_LSB);

  rbd_regfile #(.ROWS(ROWS), .BND_W(BND_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (req_valid),
    .wr         (cfg_wr),
    .wr_row     (cfg_row),
    .wr_bound   (cfg_bound),
    .wr_dense   (cfg_dense),
    .bounds     (bounds),
    .dense      (dense),
    .pend_valid (pend_valid),
    .commit_any (commit_any)
  );

  rbd_match #(.ROWS(ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W)) u_match (
    .page      (page),
    .bounds    (bounds),
    .dense     (dense),
    .sel       (sel_nxt),
    .any_row   (any_nxt),
    .dense_hit (dense_hit)
  );

  rbd_out #(.ROWS(ROWS), .LANES(LANES), .COPIES(2)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (req_valid),
    .rascas   (mode_rascas),
    .sel      (sel_nxt),
    .any_row  (any_nxt),
    .be       (req_be),
    .bank_in  (bank_nxt),
    .sel_n    (sel_copies),
    .lane_n   (lane_n),
    .bank_sel (bank_sel),
    .hit      (hit),
    .miss     (miss)
  );

  assign sel_a_n = sel_copies[0];
  assign sel_b_n = sel_copies[1];

endmodule

// File: rtl/row_bound_dec_chk.sv
module row_bound_dec_chk #(
  parameter int ROWS  = 8,
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             mode_rascas,
  input logic [ROWS-1:0]  sel_a_n,
  input logic [ROWS-1:0]  sel_b_n,
  input logic [LANES-1:0] lane_n,
  input logic [1:0]       bank_sel,
  input logic             hit,
  input logic             miss,
  input logic             pend_valid
);

  // R4
  sel_copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a_n == sel_b_n);

  // R3
  single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_a_n));

  // R5
  miss_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (&sel_a_n && bank_sel == 2'b00));

  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

  // R2
  hit_has_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(~sel_a_n) == 1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&sel_a_n && !hit && !miss && &lane_n));

  // R8
  rascas_miss_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_rascas) |=> (miss |-> &lane_n));

  // R10
  park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && req_valid) |=> pend_valid);

  // R10
  park_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !req_valid) |=> !pend_valid);

endmodule

bind row_bound_dec row_bound_dec_chk #(.ROWS(ROWS), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .mode_rascas (mode_rascas),
  .sel_a_n     (sel_a_n),
  .sel_b_n     (sel_b_n),
  .lane_n      (lane_n),
  .bank_sel    (bank_sel),
  .hit         (hit),
  .miss        (miss),
  .pend_valid  (pend_valid)
);

// File: tb/row_bound_dec_tb_top.sv
module row_bound_dec_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_row;
  logic [7:0]  cfg_bound;
  logic        cfg_dense;
  logic        mode_rascas;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [7:0]  req_be;
  logic [7:0]  sel_a_n, sel_b_n, lane_n;
  logic [1:0]  bank_sel;
  logic        hit, miss;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  row_bound_dec dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_row(cfg_row),
    .cfg_bound(cfg_bound), .cfg_dense(cfg_dense), .mode_rascas(mode_rascas),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .lane_n(lane_n),
    .bank_sel(bank_sel), .hit(hit), .miss(miss)
  );

  always #(PERIOD/2) clk = ~clk;

  // Behavioural reference: a list of running totals scanned from row 0.
  int   m_bnd [8];
  bit   m_dns [8];
  bit   m_pv;
  int   m_prow, m_pbnd;
  bit   m_pdns;
  logic [7:0] e_sel, e_lane;
  logic [1:0] e_bank;
  logic       e_hit, e_miss;
  string      e_tag;
  bit         started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bnd[i]) begin m_bnd[i] = 0; m_dns[i] = 0; end
      m_pv = 0;
      e_sel = 8'hFF; e_lane = 8'hFF; e_bank = 0; e_hit = 0; e_miss = 0;
    end else begin
      if (req_valid) begin
        int pg;
        int row;
        pg  = int'(req_addr >> 23);
        row = -1;
        for (int i = 0; i < 8; i++) if (row < 0 && pg < m_bnd[i]) row = i;
        e_hit  = (row >= 0);
        e_miss = (row < 0);
        e_sel  = (row >= 0) ? ~(8'h01 << row) : 8'hFF;
        if (row < 0)          e_bank = 2'b00;
        else if (m_dns[row])  e_bank = req_addr[14:13];
        else                  e_bank = {1'b0, req_addr[12]};
        e_lane = (mode_rascas && row < 0) ? 8'hFF : ~req_be;
      end else begin
        e_sel = 8'hFF; e_lane = 8'hFF; e_bank = 0; e_hit = 0; e_miss = 0;
      end
      if (req_valid) begin
        if (cfg_wr) begin
          m_pv = 1; m_prow = int'(cfg_row); m_pbnd = int'(cfg_bound); m_pdns = cfg_dense;
        end
      end else begin
        if (m_pv) begin m_bnd[m_prow] = m_pbnd; m_dns[m_prow] = m_pdns; end
        if (cfg_wr) begin m_bnd[cfg_row] = int'(cfg_bound); m_dns[cfg_row] = cfg_dense; end
        m_pv = 0;
      end
    end
    e_tag   = cur_tag;
    started = 1;
  end

  task automatic cmp(input string req, input string fld, input logic [7:0] got,
                     input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", req, e_tag, fld, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R2", "sel_a_n", sel_a_n, e_sel);
      cmp("R4", "sel_b_n", sel_b_n, e_sel);
      cmp("R5", "hit",  {7'b0, hit},  {7'b0, e_hit});
      cmp("R5", "miss", {7'b0, miss}, {7'b0, e_miss});
      cmp("R6/R7", "bank_sel", {6'b0, bank_sel}, {6'b0, e_bank});
      cmp("R8", "lane_n", lane_n, e_lane);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic write_row(input int row, input int bnd, input bit dns);
    @(negedge clk);
    cfg_wr = 1; cfg_row = 3'(row); cfg_bound = 8'(bnd); cfg_dense = dns;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [31:0] pg(input int p, input int low);
    return (32'(p) << 23) | 32'(low);
  endfunction

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_row = 0; cfg_bound = 0; cfg_dense = 0;
    mode_rascas = 0; req_valid = 0; req_addr = 0; req_be = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, zero boundaries miss
    cur_tag = "R1";
    lookup(pg(0, 0), 8'hFF);
    lookup(pg(3, 32'h100), 8'h0F);

    // Rows: 0:[0,4) 16Mb, 1 empty, 2:[4,8) 64Mb, 3 empty, 4:[8,9) 64Mb, 5:[9,16) 16Mb
    cur_tag = "R2";
    write_row(0, 4, 0);  write_row(1, 4, 1);
    write_row(2, 8, 1);  write_row(3, 8, 0);
    write_row(4, 9, 1);  write_row(5, 16, 0);
    write_row(6, 16, 1); write_row(7, 16, 1);
    lookup(pg(0, 0), 8'hFF);
    lookup(pg(3, 32'h7FFFFF), 8'h01);
    lookup(pg(4, 0), 8'h80);
    lookup(pg(8, 0), 8'h3C);
    lookup(pg(9, 0), 8'hA5);
    lookup(pg(15, 32'h7FFFFF), 8'h5A);
    // R3: pages right at boundaries of empty rows
    cur_tag = "R3";
    lookup(pg(4, 32'h10), 8'hFF);
    lookup(pg(8, 32'h20), 8'hFF);
    // R5: above all memory
    cur_tag = "R5";
    lookup(pg(16, 0), 8'h33);
    lookup(32'hFFFF_FFFF, 8'hC3);
    // R6 / R7: bank bits 12, 13, 14
    cur_tag = "R6";
    lookup(pg(1, 32'h1000), 8'hFF);
    lookup(pg(10, 32'h7000), 8'hFF);
    cur_tag = "R7";
    lookup(pg(5, 32'h2000), 8'hFF);
    lookup(pg(6, 32'h4000), 8'hFF);
    lookup(pg(8, 32'h7000), 8'hFF);
    // R8: RAS/CAS mode lanes idle on miss, follow enables on hit
    cur_tag = "R8";
    @(negedge clk); mode_rascas = 1;
    lookup(pg(2, 0), 8'h96);
    lookup(pg(20, 0), 8'h96);
    @(negedge clk); mode_rascas = 0;
    lookup(pg(20, 0), 8'h69);
    // R9: back-to-back then idle
    cur_tag = "R9";
    @(negedge clk); req_valid = 1; req_addr = pg(0, 0); req_be = 8'h0F;
    @(negedge clk); req_addr = pg(9, 0);
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    // R10: write during a held lookup is parked
    cur_tag = "R10";
    @(negedge clk); req_valid = 1; req_addr = pg(3, 0); req_be = 8'hFF;
    cfg_wr = 1; cfg_row = 0; cfg_bound = 2; cfg_dense = 1;
    @(negedge clk); cfg_wr = 0;
    @(negedge clk);
    @(negedge clk); req_valid = 0;
    lookup(pg(3, 0), 8'hFF);
    lookup(pg(1, 32'h6000), 8'hFF);
    // R11: later parked write replaces earlier; landing-cycle write wins
    cur_tag = "R11";
    @(negedge clk); req_valid = 1; req_addr = pg(13, 0); req_be = 8'hFF;
    cfg_wr = 1; cfg_row = 5; cfg_bound = 12; cfg_dense = 0;
    @(negedge clk); cfg_bound = 14;
    @(negedge clk); cfg_wr = 0;
    @(negedge clk); req_valid = 0;
    lookup(pg(13, 0), 8'hFF);
    @(negedge clk); req_valid = 1; req_addr = pg(14, 0);
    cfg_wr = 1; cfg_row = 5; cfg_bound = 13; cfg_dense = 0;
    @(negedge clk); req_valid = 0; cfg_bound = 15;
    @(negedge clk); cfg_wr = 0;
    lookup(pg(14, 0), 8'hFF);
    lookup(pg(15, 0), 8'hFF);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule